// File: doc/BRIEF.md
# ECC Memory Datapath with Scrubbing

This block sits between a host port and a memory array of 72-bit words (64 data bits plus 8 check bits). It accepts one host request at a time, either a read or a write with byte enables. Every write that covers a whole word stores freshly computed check bits with the data. A write that covers only some bytes becomes a read, a merge and a full write whenever checking is active for that word. When checking is off, the write goes straight to memory with per-byte strobes.

On every read while checking is active, the stored word is decoded. A single flipped bit anywhere in the 72 bits is a correctable error, and two flipped bits are an uncorrectable error. A 2-bit integrity mode, common to all rows, chooses the response:

- no checking;
- flag errors only;
- flag and return corrected data;
- flag, correct and silently write the corrected word back. This keeps a later second flip in the same word from turning into an uncorrectable double error.

A per-row input marks rows that have no check storage, and those rows are never checked. Each error raises a one-cycle pulse and records the failing word address and its row.

Top module: `ecc_scrub_dp`

## Requirements
- R1: A write with all eight byte enables set takes one memory write cycle with strobe 9'h1FF. It stores {check[7:0], data[63:0]}. Data bit j sits at the j-th position, counting up from 3, among positions 1..71 that are not powers of two. Check bit i (i<7) is the XOR of the data bits whose position has bit i set. Check bit 7 makes the XOR of all 72 stored bits zero.
- R2: A write with some byte enables clear, while checking is active (mode not 00 and the row has check storage), first reads the word. It then writes the merge of the old data (corrected in modes 10/11) with the enabled new bytes, with strobe 9'h1FF and recomputed check bits. The host sees busy for three cycles.
- R3: A partial write while checking is off (mode 00, or row flagged) performs no memory read. It takes one write cycle with strobe {1'b0, be}, so the stored check byte is left untouched.
- R4: In mode 01, single and double bit errors raise ce_pulse or ue_pulse, and rdata returns the stored data unmodified.
- R5: In mode 10, a single flipped bit (data or check) raises ce_pulse and rdata returns the original data. No memory write follows.
- R6: In mode 11, a correctable read error is additionally followed by one full write of the corrected word to the same address. A later read of that word then finds no error.
- R7: Two flipped bits raise ue_pulse (never ce_pulse), rdata returns the stored data, and no writeback happens.
- R8: In mode 00, or for an address whose row bit in row_noecc is 1, reads raise no error pulse and return raw data. The row is addr[AW-1 -: log2(ROWS)].
- R9: err_addr and err_row reset to 0. They load the word address and row of each access that raises an error pulse, and hold otherwise.
- R10: If the read phase of a partial write finds an uncorrectable error, ue_pulse is raised and the write is still performed, merging the new bytes with the uncorrected old data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, taken when busy is low |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Word address |
| wdata | input | 64 | Write data |
| be | input | 8 | Byte enables for writes |
| mode | input | 2 | Integrity mode: 00 off, 01 detect, 10 correct, 11 correct and write back |
| row_noecc | input | ROWS | Per-row flag: 1 = row has no check storage |
| busy | output | 1 | Request in progress |
| rvalid | output | 1 | One-cycle read data strobe |
| rdata | output | 64 | Read data |
| ce_pulse | output | 1 | Correctable error pulse |
| ue_pulse | output | 1 | Uncorrectable error pulse |
| err_addr | output | AW | Address of last error |
| err_row | output | log2(ROWS) | Row of last error |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | AW | Memory word address |
| mem_wstrb | output | 9 | Byte strobes, bit 8 = check byte |
| mem_wdata | output | 72 | {check, data} to memory |
| mem_rdata | input | 72 | {check, data} from memory, one cycle after a read |

## Verification
The assertions guard several rules on every cycle:
- the check byte is only ever written with the whole data word;
- partial writes take the read-merge path exactly when checking is active, and go straight to memory otherwise;
- the merge write is always a full word;
- writebacks after a plain read occur only in mode 11;
- disabled checking never pulses;
- the two error pulses are never high together;
- the error address holds when no error is flagged.

Only the bench's scenarios can show the values themselves: that the stored check bits follow the code layout, that a given flipped bit is really restored, that a scrubbed word reads clean afterwards, and that the merged bytes land correctly.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

    localparam int DATA_W  = 64;
    localparam int CHK_W   = 8;
    localparam int CODE_W  = DATA_W + CHK_W;
    localparam int SYN_W   = CHK_W - 1;
    localparam int BYTES_W = DATA_W / 8;
    localparam int STRB_W  = CODE_W / 8;
    localparam int TOP_POS = CODE_W - 1;

    typedef enum logic [1:0] {
        MODE_OFF     = 2'b00,
        MODE_DETECT  = 2'b01,
        MODE_CORRECT = 2'b10,
        MODE_SCRUB   = 2'b11
    } integ_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_CHECK,
        ST_WRITE
    } dp_state_e;

    function automatic bit is_pow2(int v);
        return (v & (v - 1)) == 0;
    endfunction

    // Code position (1..TOP_POS) of data bit j: j-th non-power-of-two slot.
    function automatic int data_pos(int j);
        int cnt;
        cnt = 0;
        for (int p = 1; p <= TOP_POS; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == j) return p;
                cnt++;
            end
        end
        return 0;
    endfunction

    // Data bits that feed check bit i.
    function automatic logic [DATA_W-1:0] chk_mask(int i);
        logic [DATA_W-1:0] m;
        int cnt;
        m   = '0;
        cnt = 0;
        for (int p = 1; p <= TOP_POS; p++) begin
            if (!is_pow2(p)) begin
                m[cnt] = ((p >> i) & 1) != 0;
                cnt++;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc
    import ecc_scrub_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  chk
);
    logic [SYN_W-1:0] ham;

    for (genvar i = 0; i < SYN_W; i++) begin : g_col
        localparam logic [DATA_W-1:0] MSK = chk_mask(i);
        assign ham[i] = ^(data & MSK);
    end

    assign chk = {^{data, ham}, ham};
endmodule

// File: rtl/ecc_dec.sv
module ecc_dec
    import ecc_scrub_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [DATA_W-1:0] data_fix,
    output logic              ce,
    output logic              ue
);
    logic [CHK_W-1:0]  calc;
    logic [SYN_W-1:0]  syn;
    logic              par;
    logic [DATA_W-1:0] hit;
    logic              syn_single;

    ecc_enc u_enc (
        .data (code[DATA_W-1:0]),
        .chk  (calc)
    );

    assign syn = calc[SYN_W-1:0] ^ code[DATA_W +: SYN_W];
    assign par = ^code;

    for (genvar j = 0; j < DATA_W; j++) begin : g_hit
        localparam int P = data_pos(j);
        assign hit[j] = (syn == SYN_W'(P));
    end

    assign syn_single = (syn & (syn - 1'b1)) == '0;

    always_comb begin
        ce       = 1'b0;
        ue       = 1'b0;
        data_fix = code[DATA_W-1:0];
        if (par) begin
            if (syn_single) begin
                ce = 1'b1;                  // flip in a check bit
            end else if (|hit) begin
                ce       = 1'b1;
                data_fix = code[DATA_W-1:0] ^ hit;
            end else begin
                ue = 1'b1;                  // syndrome points outside the word
            end
        end else if (syn != '0) begin
            ue = 1'b1;
        end
    end
endmodule

// File: rtl/ecc_merge.sv
module ecc_merge
    import ecc_scrub_pkg::*;
(
    input  logic [DATA_W-1:0]  old_data,
    input  logic [DATA_W-1:0]  new_data,
    input  logic [BYTES_W-1:0] be,
    output logic [DATA_W-1:0]  merged
);
    for (genvar b = 0; b < BYTES_W; b++) begin : g_byte
        assign merged[b*8 +: 8] = be[b] ? new_data[b*8 +: 8] : old_data[b*8 +: 8];
    end
endmodule

// File: rtl/ecc_scrub_dp.sv
module ecc_scrub_dp
    import ecc_scrub_pkg::*;
#(
    parameter int AW   = 10,
    parameter int ROWS = 8,
    localparam int RB  = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req,
    input  logic                we,
    input  logic [AW-1:0]       addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [BYTES_W-1:0]  be,
    input  logic [1:0]          mode,
    input  logic [ROWS-1:0]     row_noecc,
    output logic                busy,
    output logic                rvalid,
    output logic [DATA_W-1:0]   rdata,
    output logic                ce_pulse,
    output logic                ue_pulse,
    output logic [AW-1:0]       err_addr,
    output logic [RB-1:0]       err_row,
    output logic                mem_en,
    output logic                mem_we,
    output logic [AW-1:0]       mem_addr,
    output logic [STRB_W-1:0]   mem_wstrb,
    output logic [CODE_W-1:0]   mem_wdata,
    input  logic [CODE_W-1:0]   mem_rdata
);
    dp_state_e          state_q;
    logic               c_we;
    logic [AW-1:0]      c_addr;
    logic [DATA_W-1:0]  c_data;
    logic [BYTES_W-1:0] c_be;
    integ_mode_e        c_mode;
    logic [DATA_W-1:0]  wr_data_q;
    logic [STRB_W-1:0]  wr_strb_q;
    logic               rvalid_q, ce_q, ue_q;
    logic [DATA_W-1:0]  rdata_q;
    logic [AW-1:0]      err_addr_q;
    logic [RB-1:0]      err_row_q;

    logic [RB-1:0]      row_sel;
    integ_mode_e        eff_mode;
    logic               full_be;
    logic [CHK_W-1:0]   wr_chk;
    logic [DATA_W-1:0]  dec_data, old_data, merged;
    logic               dec_ce, dec_ue, ce_hit, ue_hit;

    assign row_sel  = addr[AW-1 -: RB];
    assign eff_mode = row_noecc[row_sel] ? MODE_OFF : integ_mode_e'(mode);
    assign full_be  = &be;

    ecc_enc u_enc (
        .data (wr_data_q),
        .chk  (wr_chk)
    );

    ecc_dec u_dec (
        .code     (mem_rdata),
        .data_fix (dec_data),
        .ce       (dec_ce),
        .ue       (dec_ue)
    );

    assign ce_hit   = (c_mode != MODE_OFF) && dec_ce;
    assign ue_hit   = (c_mode != MODE_OFF) && dec_ue;
    assign old_data = (c_mode == MODE_CORRECT || c_mode == MODE_SCRUB)
                      ? dec_data : mem_rdata[DATA_W-1:0];

    ecc_merge u_merge (
        .old_data (old_data),
        .new_data (c_data),
        .be       (c_be),
        .merged   (merged)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            c_we       <= 1'b0;
            c_addr     <= '0;
            c_data     <= '0;
            c_be       <= '0;
            c_mode     <= MODE_OFF;
            wr_data_q  <= '0;
            wr_strb_q  <= '0;
            rvalid_q   <= 1'b0;
            rdata_q    <= '0;
            ce_q       <= 1'b0;
            ue_q       <= 1'b0;
            err_addr_q <= '0;
            err_row_q  <= '0;
        end else begin
            rvalid_q <= 1'b0;
            ce_q     <= 1'b0;
            ue_q     <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req) begin
                        c_we   <= we;
                        c_addr <= addr;
                        c_data <= wdata;
                        c_be   <= be;
                        c_mode <= eff_mode;
                        if (we && (full_be || eff_mode == MODE_OFF)) begin
                            wr_data_q <= wdata;
                            wr_strb_q <= full_be ? '1 : {1'b0, be};
                            state_q   <= ST_WRITE;
                        end else begin
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: state_q <= ST_CHECK;
                ST_CHECK: begin
                    if (!c_we) begin
                        rvalid_q <= 1'b1;
                        rdata_q  <= old_data;
                    end
                    ce_q <= ce_hit;
                    ue_q <= ue_hit;
                    if (ce_hit || ue_hit) begin
                        err_addr_q <= c_addr;
                        err_row_q  <= c_addr[AW-1 -: RB];
                    end
                    if (c_we) begin
                        wr_data_q <= merged;
                        wr_strb_q <= '1;
                        state_q   <= ST_WRITE;
                    end else if (c_mode == MODE_SCRUB && ce_hit) begin
                        wr_data_q <= dec_data;
                        wr_strb_q <= '1;
                        state_q   <= ST_WRITE;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                ST_WRITE: state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign rvalid    = rvalid_q;
    assign rdata     = rdata_q;
    assign ce_pulse  = ce_q;
    assign ue_pulse  = ue_q;
    assign err_addr  = err_addr_q;
    assign err_row   = err_row_q;
    assign mem_en    = (state_q == ST_READ) || (state_q == ST_WRITE);
    assign mem_we    = (state_q == ST_WRITE);
    assign mem_addr  = c_addr;
    assign mem_wstrb = wr_strb_q;
    assign mem_wdata = {wr_chk, wr_data_q};

    AST_CHK_BYTE_FULL: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_wstrb[STRB_W-1]) |-> (&mem_wstrb[BYTES_W-1:0])); // R1
    AST_PARTIAL_READS_FIRST: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req && we && !full_be && eff_mode != MODE_OFF)
        |=> (state_q == ST_READ)); // R2
    AST_MERGE_FULL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && c_we) |=> (mem_we && (&mem_wstrb))); // R2
    AST_OFF_DIRECT_WRITE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req && we && eff_mode == MODE_OFF)
        |=> (state_q == ST_WRITE)); // R3
    AST_WB_ONLY_SCRUB: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && !c_we)
        |=> (state_q != ST_WRITE || c_mode == MODE_SCRUB)); // R6
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ce_q && ue_q)); // R7
    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_CHECK && c_mode == MODE_OFF) |=> (!ce_q && !ue_q)); // R8
    AST_ERR_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ce_q || ue_q || $stable(err_addr_q))); // R9
endmodule

// File: tb/ecc_scrub_dp_bench.sv
module ecc_scrub_dp_bench;
    localparam int AW   = 10;
    localparam int ROWS = 8;
    localparam int RB   = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0, we = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [63:0]   wdata = '0;
    logic [7:0]    be = '0;
    logic [1:0]    mode = 2'b10;
    logic [ROWS-1:0] row_noecc = '0;
    logic          busy, rvalid, ce_pulse, ue_pulse;
    logic [63:0]   rdata;
    logic [AW-1:0] err_addr;
    logic [RB-1:0] err_row;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [8:0]    mem_wstrb;
    logic [71:0]   mem_wdata;
    logic [71:0]   mem_rdata;

    always #5 clk = ~clk;

    ecc_scrub_dp #(.AW(AW), .ROWS(ROWS)) u_ecc_scrub_dp (
        .clk, .rst, .req, .we, .addr, .wdata, .be, .mode, .row_noecc,
        .busy, .rvalid, .rdata, .ce_pulse, .ue_pulse, .err_addr, .err_row,
        .mem_en, .mem_we, .mem_addr, .mem_wstrb, .mem_wdata, .mem_rdata
    );

    // memory model with error injection port
    logic [71:0]   mem [0:(1<<AW)-1];
    int            wr_cnt = 0, rd_cnt = 0;
    logic          inj_en = 1'b0;
    logic [AW-1:0] inj_addr = '0;
    logic [71:0]   inj_mask = '0;

    always @(posedge clk) begin
        if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
        else if (mem_en && mem_we) begin
            for (int b = 0; b < 9; b++)
                if (mem_wstrb[b]) mem[mem_addr][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            wr_cnt <= wr_cnt + 1;
        end else if (mem_en) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt    <= rd_cnt + 1;
        end
    end

    // sticky capture of one-cycle outputs
    logic        cap_clr = 1'b0;
    logic        cap_rv = 1'b0, cap_ce = 1'b0, cap_ue = 1'b0;
    logic [63:0] cap_rd = '0;
    always @(posedge clk) begin
        if (cap_clr) begin
            cap_rv <= 1'b0; cap_ce <= 1'b0; cap_ue <= 1'b0;
        end else begin
            if (rvalid)   begin cap_rv <= 1'b1; cap_rd <= rdata; end
            if (ce_pulse) cap_ce <= 1'b1;
            if (ue_pulse) cap_ue <= 1'b1;
        end
    end

    int n_chk = 0, n_fail = 0;
    int busy_cyc;
    int cyc = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // independent encoder written from the R1 layout
    function automatic logic [7:0] bchk(input logic [63:0] d);
        logic [7:0] c;
        int p;
        c = '0;
        p = 2;
        for (int j = 0; j < 64; j++) begin
            p++;
            while ((p & (p - 1)) == 0) p++;
            for (int i = 0; i < 7; i++)
                if (((p >> i) & 1) != 0) c[i] = c[i] ^ d[j];
        end
        c[7] = ^{d, c[6:0]};
        return c;
    endfunction

    function automatic logic [63:0] bmerge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] e);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[b*8 +: 8] = e[b] ? n[b*8 +: 8] : o[b*8 +: 8];
        return r;
    endfunction

    task automatic do_op(input logic w, input logic [AW-1:0] a, input logic [63:0] d, input logic [7:0] e);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; be = e; cap_clr = 1'b1;
        busy_cyc = 0;
        @(posedge clk);
        #1 req = 1'b0; cap_clr = 1'b0;
        for (int k = 0; k < 50; k++) begin
            @(negedge clk);
            if (!busy) break;
            busy_cyc++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic inject(input logic [AW-1:0] a, input logic [71:0] m);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_mask = m;
        @(posedge clk);
        #1 inj_en = 1'b0;
    endtask

    // mode[21:20] flip1[19:12] flip2[11:4] ce[3] ue[2] fixed[1] writeback[0]; 8'hFF = no flip
    localparam logic [21:0] TV [10] = '{
        {2'd2, 8'hFF, 8'hFF, 4'b0010},
        {2'd2, 8'd5,  8'hFF, 4'b1010},
        {2'd3, 8'd40, 8'hFF, 4'b1011},
        {2'd1, 8'd10, 8'hFF, 4'b1000},
        {2'd2, 8'd3,  8'd9,  4'b0100},
        {2'd3, 8'd64, 8'hFF, 4'b1011},
        {2'd1, 8'd20, 8'd21, 4'b0100},
        {2'd0, 8'd7,  8'hFF, 4'b0000},
        {2'd3, 8'd71, 8'hFF, 4'b1011},
        {2'd3, 8'd1,  8'd2,  4'b0100}
    };

    initial begin
        logic [63:0] d, n, m;
        logic [71:0] msk, raw;
        logic [AW-1:0] a;
        int w0, r0;
        string tg;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!busy && !rvalid && !ce_pulse && !ue_pulse, "R9 reset outputs idle",
            {68'd0, busy, rvalid, ce_pulse, ue_pulse}, 72'd0);
        chk(err_addr == '0 && err_row == '0, "R9 reset err_addr/err_row", 72'(err_addr), 72'd0);

        // R1: full write stores data with layout check bits
        mode = 2'b10;
        d = 64'hDEAD_BEEF_0123_4567;
        r0 = rd_cnt;
        do_op(1'b1, 10'd100, d, 8'hFF);
        chk(mem[100] == {bchk(d), d}, "R1 stored codeword", mem[100], {bchk(d), d});
        chk(busy_cyc == 1 && rd_cnt == r0, "R1 single write cycle", 72'(busy_cyc), 72'd1);

        // table of read scenarios (R4..R8)
        for (int i = 0; i < 10; i++) begin
            a = AW'(i + 1);
            d = 64'h0123_4567_89AB_CDEF ^ (64'(i + 1) * 64'h9E37_79B9_7F4A_7C15);
            mode = 2'b10;
            do_op(1'b1, a, d, 8'hFF);
            msk = '0;
            if (TV[i][19:12] != 8'hFF) msk[TV[i][19:12]] = 1'b1;
            if (TV[i][11:4]  != 8'hFF) msk[TV[i][11:4]]  = 1'b1;
            inject(a, msk);
            raw  = {bchk(d), d} ^ msk;
            mode = TV[i][21:20];
            case (mode)
                2'd0: tg = "R8 mode off";
                2'd1: tg = "R4 detect";
                2'd2: tg = "R5 correct";
                default: tg = "R6 scrub";
            endcase
            if (TV[i][2]) tg = {tg, " R7 double"};
            w0 = wr_cnt;
            do_op(1'b0, a, '0, 8'h00);
            chk(cap_rv && cap_rd == (TV[i][1] ? d : raw[63:0]), {tg, " rdata"},
                72'(cap_rd), 72'(TV[i][1] ? d : raw[63:0]));
            chk(cap_ce == TV[i][3] && cap_ue == TV[i][2], {tg, " ce/ue"},
                {70'd0, cap_ce, cap_ue}, {70'd0, TV[i][3], TV[i][2]});
            chk((wr_cnt - w0) == int'(TV[i][0]), {tg, " writeback count"},
                72'(wr_cnt - w0), 72'(TV[i][0]));
            if (TV[i][0])
                chk(mem[a] == {bchk(d), d}, {tg, " scrubbed word"}, mem[a], {bchk(d), d});
            if (TV[i][3] || TV[i][2])
                chk(err_addr == a, "R9 err_addr capture", 72'(err_addr), 72'(a));
        end

        // R6: scrubbed word (entry 2 at address 3) reads clean
        mode = 2'b10;
        do_op(1'b0, 10'd3, '0, 8'h00);
        chk(!cap_ce && !cap_ue, "R6 re-read after scrub is clean", {70'd0, cap_ce, cap_ue}, 72'd0);

        // R2: partial write with a single error in the old word
        d = 64'h1111_2222_3333_4444;
        n = 64'hAAAA_BBBB_CCCC_DDDD;
        do_op(1'b1, 10'd101, d, 8'hFF);
        inject(10'd101, 72'd1 << 12);
        r0 = rd_cnt;
        do_op(1'b1, 10'd101, n, 8'h0F);
        m = bmerge(d, n, 8'h0F);
        chk(mem[101] == {bchk(m), m}, "R2 merged corrected word", mem[101], {bchk(m), m});
        chk(busy_cyc == 3 && rd_cnt == r0 + 1, "R2 stall and read phase", 72'(busy_cyc), 72'd3);
        chk(cap_ce && !cap_ue, "R2 ce during read phase", {70'd0, cap_ce, cap_ue}, 72'd2);

        // R10: partial write over an uncorrectable word
        do_op(1'b1, 10'd102, d, 8'hFF);
        msk = (72'd1 << 4) | (72'd1 << 30);
        inject(10'd102, msk);
        w0 = wr_cnt;
        do_op(1'b1, 10'd102, n, 8'hF0);
        m = bmerge(d ^ msk[63:0], n, 8'hF0);
        chk(mem[102] == {bchk(m), m} && wr_cnt == w0 + 1, "R10 write performed", mem[102], {bchk(m), m});
        chk(cap_ue && !cap_ce, "R10 ue reported", {70'd0, cap_ce, cap_ue}, 72'd1);

        // R3: mode off partial write goes direct
        mode = 2'b00;
        do_op(1'b1, 10'd103, d, 8'hFF);
        r0 = rd_cnt;
        do_op(1'b1, 10'd103, n, 8'h33);
        m = bmerge(d, n, 8'h33);
        chk(mem[103] == {bchk(d), m}, "R3 mode off direct partial", mem[103], {bchk(d), m});
        chk(rd_cnt == r0 && busy_cyc == 1, "R3 mode off no read", 72'(rd_cnt - r0), 72'd0);

        // R3/R8: row 5 flagged without check storage
        mode = 2'b11;
        row_noecc = 8'b0010_0000;
        a = 10'd644;
        do_op(1'b1, a, d, 8'hFF);
        r0 = rd_cnt;
        do_op(1'b1, a, n, 8'h01);
        m = bmerge(d, n, 8'h01);
        chk(mem[a] == {bchk(d), m} && rd_cnt == r0, "R3 flagged row direct partial", mem[a], {bchk(d), m});
        inject(a, 72'd1 << 9);
        w0 = wr_cnt;
        do_op(1'b0, a, '0, 8'h00);
        raw = {bchk(d), m} ^ (72'd1 << 9);
        chk(cap_rd == raw[63:0] && !cap_ce && !cap_ue && wr_cnt == w0, "R8 flagged row unchecked",
            72'(cap_rd), 72'(raw[63:0]));

        // R9: error in row 5 once checked, then clean read elsewhere holds it
        row_noecc = '0;
        mode = 2'b10;
        do_op(1'b0, a, '0, 8'h00);
        chk(cap_ce && err_addr == a && err_row == 3'd5, "R9 err row capture",
            {60'd0, err_row, err_addr}, {60'd0, 3'd5, a});
        do_op(1'b0, 10'd100, '0, 8'h00);
        chk(!cap_ce && err_addr == a && err_row == 3'd5, "R9 err_addr holds on clean read",
            72'(err_addr), 72'(a));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule